// File: doc/BRIEF.md
# EEPROM Burst Transaction Sequencer

This block turns a stream of incoming serial bytes into EEPROM page writes, and turns a read request into a random-address burst read. Incoming bytes go into a write queue. Once that queue holds enough bytes, the sequencer issues a write burst to a byte-level two-wire bus engine. The burst carries the device address, the current write word address and a fixed number of payload bytes.

A pulse on the read-request input starts a burst of a different shape. It writes the device address, sends the current read word address, sends a repeated start with the device read address, and then reads a fixed number of bytes. The returned bytes are collected in a read queue. They are handed to the serial transmitter one per cycle whenever the transmitter reports ready.

The engine receives one request, one command code and one data byte per bus byte. It answers each with a one-cycle done pulse. The sequencer keeps a separate word address for reads and for writes. Each advances by its burst's payload length when the burst completes. Bit timing on the bus and the serial line itself lie outside the block.

Top module: `eeprom_burst_seq`

## Requirements
- R1: After reset, `eng_req` and `tx_vld` are low, `eng_cmd` and `eng_wr_data` are zero, and both word addresses are 0.
- R2: A write burst starts from idle when the write queue holds more than WR_LEN-2 bytes. It carries WR_LEN-2 payload bytes, taken from the queue head in arrival order.
- R3: Command bits are START = bit 0, WRITE = bit 1, READ = bit 2 and STOP = bit 3. A write burst issues these bytes in order:
  - START|WRITE with {DEV_ADDR,0};
  - WRITE with the write word address;
  - WRITE with each payload byte, except the last byte, which is WRITE|STOP.
- R4: A read burst issues these bytes in order:
  - START|WRITE with {DEV_ADDR,0};
  - WRITE with the read word address;
  - START|WRITE with {DEV_ADDR,1};
  - RD_LEN-3 READ bytes with data 0, the last of which is READ|STOP.
- R5: `eng_req` is high for exactly one cycle per bus byte. The next request follows only after an `eng_done` pulse. An `eng_done` pulse while no byte is outstanding has no effect.
- R6: A read request seen in idle wins over a pending write burst. A read request that arrives during a burst is ignored.
- R7: After the final done of a write burst, the write word address advances by WR_LEN-2. After the final done of a read burst, the read word address advances by RD_LEN-3. Both wrap modulo 2^AW.
- R8: `rx_byte` is accepted on `rx_vld` while the write queue holds fewer than FIFO_DEPTH bytes. It is dropped while the queue is full.
- R9: For each READ byte, `eng_rd_data` is captured on its done pulse. `tx_vld` equals `tx_ready` AND (the read queue is not empty). `tx_byte` is the oldest captured byte.
- R10: While `eng_req` is low, `eng_cmd` and `eng_wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Read burst request |
| rx_byte | input | 8 | Incoming serial byte |
| rx_vld | input | 1 | Incoming byte strobe |
| eng_rd_data | input | 8 | Byte returned by the bus engine |
| eng_done | input | 1 | Engine finished one byte |
| tx_ready | input | 1 | Serial transmitter can take a byte |
| tx_byte | output | 8 | Byte to the serial transmitter |
| tx_vld | output | 1 | Byte handed over this cycle |
| eng_cmd | output | 4 | Command bits for the current bus byte |
| eng_req | output | 1 | Start one bus byte |
| eng_wr_data | output | 8 | Data for the current bus byte |

## Verification
A wrong state or byte counter shows up at the first request after the fault, as a command or data byte out of place in the burst. A stale word address shows up in the second byte of the next burst of the same kind. Queue pointer faults show up as payload or transmit bytes out of order, one cycle after the affected push or pop. Because the bench's EEPROM model stores whatever is written, a read burst that covers earlier writes must return those exact bytes; this ties the two address counters together end to end.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
    localparam logic [3:0] CMD_START = 4'b0001;
    localparam logic [3:0] CMD_WRITE = 4'b0010;
    localparam logic [3:0] CMD_READ  = 4'b0100;
    localparam logic [3:0] CMD_STOP  = 4'b1000;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_REQ  = 3'd1,
        S_RD_WAIT = 3'd2,
        S_WR_REQ  = 3'd3,
        S_WR_WAIT = 3'd4,
        S_DONE    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/seq_byte_fifo.sv
module seq_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DW-1:0]                din_i,
    input  logic                         pop_i,
    output logic [DW-1:0]                dout_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o,
    output logic                         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t fs_d, fs_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic wr_ok, rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (fs_q.cnt == CW'(DEPTH));
    assign empty_o = (fs_q.cnt == '0);
    assign wr_ok   = push_i && !full_o;
    assign rd_ok   = pop_i && !empty_o;
    assign dout_o  = mem_q[fs_q.rp];
    assign count_o = fs_q.cnt;

    always_comb begin
        fs_d = fs_q;
        if (wr_ok) fs_d.wp = bump(fs_q.wp);
        if (rd_ok) fs_d.rp = bump(fs_q.rp);
        case ({wr_ok, rd_ok})
            2'b10:   fs_d.cnt = fs_q.cnt + 1'b1;
            2'b01:   fs_d.cnt = fs_q.cnt - 1'b1;
            default: fs_d.cnt = fs_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[fs_q.wp] <= din_i;
    end

    // R8: a push into a full queue changes nothing
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> $stable(count_o));
    // R8: occupancy never passes the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CW'(DEPTH) && !pop_i) |=> (count_o == CW'(DEPTH)));
endmodule

// File: rtl/seq_burst_ctrl.sv
module seq_burst_ctrl
    import eeprom_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int WR_LEN = 5,
    parameter int RD_LEN = 6,
    parameter int AW     = 8,
    parameter int FCW    = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req_i,
    input  logic [FCW-1:0] wf_count_i,
    input  logic [7:0]     wf_head_i,
    input  logic           done_i,
    output logic           wf_pop_o,
    output logic           rf_push_o,
    output logic           req_o,
    output logic [3:0]     cmd_o,
    output logic [7:0]     wr_data_o
);
    localparam int MAXLEN = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
    localparam int CW = $clog2(MAXLEN + 1);
    localparam logic [AW-1:0] WR_STEP = AW'(WR_LEN - 2);
    localparam logic [AW-1:0] RD_STEP = AW'(RD_LEN - 3);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_LEN - 1);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_LEN - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] waddr;
        logic [AW-1:0] raddr;
    } ctrl_st_t;

    ctrl_st_t cs_d, cs_q;
    logic wr_trig;

    assign wr_trig = (32'(wf_count_i) > WR_LEN - 2);

    always_comb begin
        cs_d      = cs_q;
        wf_pop_o  = 1'b0;
        rf_push_o = 1'b0;
        case (cs_q.st)
            S_IDLE: begin
                if (rd_req_i)     cs_d.st = S_RD_REQ;
                else if (wr_trig) cs_d.st = S_WR_REQ;
            end
            S_RD_REQ: cs_d.st = S_RD_WAIT;
            S_WR_REQ: cs_d.st = S_WR_WAIT;
            S_RD_WAIT: if (done_i) begin
                rf_push_o = (cs_q.cnt > CW'(2));
                if (cs_q.cnt == RD_LAST) begin
                    cs_d.st    = S_DONE;
                    cs_d.cnt   = '0;
                    cs_d.raddr = cs_q.raddr + RD_STEP;
                end else begin
                    cs_d.st  = S_RD_REQ;
                    cs_d.cnt = cs_q.cnt + 1'b1;
                end
            end
            S_WR_WAIT: if (done_i) begin
                wf_pop_o = (cs_q.cnt > CW'(1));
                if (cs_q.cnt == WR_LAST) begin
                    cs_d.st    = S_DONE;
                    cs_d.cnt   = '0;
                    cs_d.waddr = cs_q.waddr + WR_STEP;
                end else begin
                    cs_d.st  = S_WR_REQ;
                    cs_d.cnt = cs_q.cnt + 1'b1;
                end
            end
            default: cs_d.st = S_IDLE;
        endcase
    end

    always_comb begin
        req_o     = 1'b0;
        cmd_o     = '0;
        wr_data_o = '0;
        if (cs_q.st == S_RD_REQ) begin
            req_o = 1'b1;
            case (cs_q.cnt)
                CW'(0): begin cmd_o = CMD_START | CMD_WRITE; wr_data_o = {DEV_ADDR, 1'b0}; end
                CW'(1): begin cmd_o = CMD_WRITE; wr_data_o = 8'(cs_q.raddr); end
                CW'(2): begin cmd_o = CMD_START | CMD_WRITE; wr_data_o = {DEV_ADDR, 1'b1}; end
                default: cmd_o = (cs_q.cnt == RD_LAST) ? (CMD_READ | CMD_STOP) : CMD_READ;
            endcase
        end else if (cs_q.st == S_WR_REQ) begin
            req_o = 1'b1;
            case (cs_q.cnt)
                CW'(0): begin cmd_o = CMD_START | CMD_WRITE; wr_data_o = {DEV_ADDR, 1'b0}; end
                CW'(1): begin cmd_o = CMD_WRITE; wr_data_o = 8'(cs_q.waddr); end
                default: begin
                    cmd_o     = (cs_q.cnt == WR_LAST) ? (CMD_WRITE | CMD_STOP) : CMD_WRITE;
                    wr_data_o = wf_head_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '{st: S_IDLE, cnt: '0, waddr: '0, raddr: '0};
        else        cs_q <= cs_d;
    end

    // R5: one request cycle per bus byte
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R3, R4: STOP only rides on the last byte of a burst
    a_r3_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && cmd_o[3]) |-> (cs_q.cnt == WR_LAST || cs_q.cnt == RD_LAST));
    // R7: write address moves only on the final done of a write burst
    a_r7_waddr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_q.waddr) |-> ($past(cs_q.st) == S_WR_WAIT && $past(done_i)));
    // R7: read address moves only on the final done of a read burst
    a_r7_raddr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_q.raddr) |-> ($past(cs_q.st) == S_RD_WAIT && $past(done_i)));
    // R6: a running write burst is never turned into a read
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.st == S_WR_WAIT) |=> (cs_q.st inside {S_WR_WAIT, S_WR_REQ, S_DONE}));
    // R2: idle with a filled queue and no read request starts a write
    a_r2_wr_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.st == S_IDLE && !rd_req_i && wr_trig) |=> req_o);
endmodule

// File: rtl/eeprom_burst_seq.sv
module eeprom_burst_seq #(
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter int         WR_LEN     = 5,
    parameter int         RD_LEN     = 6,
    parameter int         FIFO_DEPTH = 256,
    parameter int         AW         = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_start,
    input  logic [7:0] rx_byte,
    input  logic       rx_vld,
    input  logic [7:0] eng_rd_data,
    input  logic       eng_done,
    input  logic       tx_ready,
    output logic [7:0] tx_byte,
    output logic       tx_vld,
    output logic [3:0] eng_cmd,
    output logic       eng_req,
    output logic [7:0] eng_wr_data
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    logic [FCW-1:0] wf_count, rf_count;
    logic [7:0]     wf_head;
    logic           wf_pop, wf_full, wf_empty;
    logic           rf_push, rf_full, rf_empty;

    seq_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_vld), .din_i(rx_byte), .pop_i(wf_pop),
        .dout_o(wf_head), .count_o(wf_count),
        .full_o(wf_full), .empty_o(wf_empty)
    );

    assign tx_vld = tx_ready && !rf_empty;

    seq_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rf_push), .din_i(eng_rd_data), .pop_i(tx_vld),
        .dout_o(tx_byte), .count_o(rf_count),
        .full_o(rf_full), .empty_o(rf_empty)
    );

    seq_burst_ctrl #(
        .DEV_ADDR(DEV_ADDR), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN),
        .AW(AW), .FCW(FCW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_req_i(rd_start), .wf_count_i(wf_count), .wf_head_i(wf_head),
        .done_i(eng_done),
        .wf_pop_o(wf_pop), .rf_push_o(rf_push),
        .req_o(eng_req), .cmd_o(eng_cmd), .wr_data_o(eng_wr_data)
    );

    // R9: the read queue only shrinks through a handover
    a_r9_rf_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_vld && !rf_push) |=> $stable(rf_count));
    // R2: the write queue only shrinks while a burst runs
    a_r2_wf_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_count != $past(rf_count) || 1'b1) && (wf_count < $past(wf_count)) |-> $past(eng_done));
    // R9: a handover never happens from an empty queue
    a_r9_no_empty_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_count == '0 && !$past(rf_push)) |-> !tx_vld);
endmodule

// File: tb/eeprom_burst_seq_test.sv
module eeprom_burst_seq_test;
    localparam int WR_LEN = 5;
    localparam int RD_LEN = 6;
    localparam int DEPTH  = 256;
    localparam logic [6:0] DEV = 7'h50;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_start = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_vld = 1'b0;
    logic [7:0] eng_rd_data = '0;
    logic eng_done = 1'b0;
    logic tx_ready = 1'b0;
    logic [7:0] tx_byte;
    logic tx_vld;
    logic [3:0] eng_cmd;
    logic eng_req;
    logic [7:0] eng_wr_data;

    always #2 clk = ~clk;

    eeprom_burst_seq #(.DEV_ADDR(DEV), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN),
                       .FIFO_DEPTH(DEPTH), .AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
        .rx_byte(rx_byte), .rx_vld(rx_vld),
        .eng_rd_data(eng_rd_data), .eng_done(eng_done), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_vld(tx_vld),
        .eng_cmd(eng_cmd), .eng_req(eng_req), .eng_wr_data(eng_wr_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    logic [7:0] mem [256];
    logic [7:0] wq[$];
    logic [7:0] txq[$];
    logic [7:0] tx_log[$];
    int exp_cmd[$];
    int exp_dat[$];
    int exp_kind[$];
    int exp_last[$];
    int wa = 0, ra = 0, ptr = 0;
    int rd_pending = 0, dropped = 0, req_seen = 0, bursts = 0;
    int first_kind = -1;
    bit busy = 0, hold = 0, stray = 0;
    int lat = 0, cur_kind = 0, cur_cmd = 0, cur_dat = 0, cur_last = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    task automatic finish_tb();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic add_item(input int c, input int d, input int k, input int l);
        exp_cmd.push_back(c); exp_dat.push_back(d);
        exp_kind.push_back(k); exp_last.push_back(l);
    endtask

    task automatic build_read();
        rd_pending--;
        if (first_kind < 0) first_kind = 2;
        add_item(3, {DEV, 1'b0}, 0, 0);
        add_item(2, ra, 0, 0);
        add_item(3, {DEV, 1'b1}, 0, 0);
        for (int k = 3; k < RD_LEN; k++)
            add_item((k == RD_LEN - 1) ? 12 : 4, 0, 2, (k == RD_LEN - 1) ? 1 : 0);
        ra = (ra + RD_LEN - 3) & 255;
    endtask

    task automatic build_write();
        if (first_kind < 0) first_kind = 1;
        add_item(3, {DEV, 1'b0}, 0, 0);
        add_item(2, wa, 0, 0);
        for (int j = 0; j < WR_LEN - 2; j++)
            add_item((j == WR_LEN - 3) ? 10 : 2, int'(wq[j]), 1, (j == WR_LEN - 3) ? 1 : 0);
        wa = (wa + WR_LEN - 2) & 255;
    endtask

    // reference model and engine, evaluated between clock edges
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                finish_tb();
            end
            // R9: handover to the transmitter
            chk(tx_vld == (tx_ready && txq.size() > 0), "R9 tx_vld",
                int'(tx_vld), int'(tx_ready && txq.size() > 0));
            if (txq.size() > 0 && tx_vld) begin
                chk(tx_byte == txq[0], "R9 tx_byte", int'(tx_byte), int'(txq[0]));
                tx_log.push_back(txq[0]);
                void'(txq.pop_front());
            end
            // R8: write queue intake
            if (rx_vld) begin
                if (wq.size() < DEPTH) wq.push_back(rx_byte);
                else dropped++;
            end
            if (eng_done) eng_done = 1'b0;
            if (eng_req) begin
                req_seen++;
                chk(!busy, "R5 request while byte outstanding", 1, 0);
                if (exp_cmd.size() == 0) begin
                    if (rd_pending > 0) build_read();
                    else if (wq.size() > WR_LEN - 2) build_write();
                end
                if (exp_cmd.size() == 0) begin
                    chk(0, "R2 unexpected request", int'(eng_cmd), 0);
                    cur_kind = 0; cur_cmd = 0; cur_dat = 0; cur_last = 0;
                end else begin
                    cur_cmd = exp_cmd.pop_front(); cur_dat = exp_dat.pop_front();
                    cur_kind = exp_kind.pop_front(); cur_last = exp_last.pop_front();
                    chk(int'(eng_cmd) == cur_cmd, "R3/R4 command", int'(eng_cmd), cur_cmd);
                    chk(int'(eng_wr_data) == cur_dat, "R3/R4/R7 data", int'(eng_wr_data), cur_dat);
                end
                busy = 1; lat = LAT;
            end else begin
                chk(eng_cmd == 4'd0 && eng_wr_data == 8'd0, "R10 idle outputs",
                    int'({eng_cmd, eng_wr_data}), 0);
                if (busy && !hold) begin
                    lat--;
                    if (lat == 0) begin
                        eng_done = 1'b1;
                        busy = 0;
                        if (cur_kind == 0 && cur_cmd == 2) ptr = cur_dat;
                        if (cur_kind == 1) begin
                            mem[ptr] = 8'(cur_dat);
                            ptr = (ptr + 1) & 255;
                            void'(wq.pop_front());
                        end
                        if (cur_kind == 2) begin
                            eng_rd_data = mem[ptr];
                            txq.push_back(mem[ptr]);
                            ptr = (ptr + 1) & 255;
                        end
                        if (cur_last != 0) bursts++;
                    end
                end else if (stray && !busy) begin
                    eng_done = 1'b1;
                    stray = 0;
                end
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_vld = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_vld = 1'b0;
    endtask

    task automatic pulse_rd(input bit counted);
        @(posedge clk); #1;
        rd_start = 1'b1;
        if (counted) rd_pending++;
        @(posedge clk); #1;
        rd_start = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 12) begin
            @(posedge clk);
            if (exp_cmd.size() == 0 && !busy && rd_pending == 0 &&
                wq.size() <= WR_LEN - 2 && !eng_req && (txq.size() == 0 || !tx_ready))
                q++;
            else
                q = 0;
        end
    endtask

    initial begin
        logic [7:0] w1[$];
        int s0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 165);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!eng_req, "R1 req after reset", int'(eng_req), 0);
        chk(!tx_vld, "R1 tx_vld after reset", int'(tx_vld), 0);
        chk(eng_cmd == 4'd0 && eng_wr_data == 8'd0, "R1 outputs after reset",
            int'({eng_cmd, eng_wr_data}), 0);

        // R5: stray done with nothing outstanding
        stray = 1;
        repeat (12) @(posedge clk);
        chk(req_seen == 0, "R5 stray done started nothing", req_seen, 0);

        // R2/R3: first write burst, address 0
        tx_ready = 1'b1;
        for (int i = 0; i < WR_LEN - 1; i++) begin
            w1.push_back(8'(8'h30 + i));
            push_byte(8'(8'h30 + i));
        end
        wait_quiet();
        chk(bursts == 1, "R2 one write burst", bursts, 1);
        chk(first_kind == 1, "R2 burst kind", first_kind, 1);

        // R4/R7/R9: read back from address 0
        pulse_rd(1);
        wait_quiet();
        chk(tx_log.size() == RD_LEN - 3, "R9 bytes handed over", tx_log.size(), RD_LEN - 3);
        for (int i = 0; i < RD_LEN - 3 && i < tx_log.size(); i++)
            chk(tx_log[i] == w1[i], "R7 read returns written byte", int'(tx_log[i]), int'(w1[i]));

        // R9: transmitter stalled, bytes wait in the queue
        tx_ready = 1'b0;
        pulse_rd(1);
        wait_quiet();
        chk(txq.size() == RD_LEN - 3, "R9 bytes held while not ready", txq.size(), RD_LEN - 3);
        @(posedge clk); #1 tx_ready = 1'b1;
        wait_quiet();
        chk(txq.size() == 0, "R9 queue drained", txq.size(), 0);

        // R6: read request wins over a write trigger in the same idle cycle
        first_kind = -1;
        s0 = wq.size();
        for (int i = s0; i < WR_LEN - 2; i++) push_byte(8'(8'h60 + i));
        @(posedge clk); #1;
        rx_vld = 1'b1; rx_byte = 8'h7E;
        @(posedge clk); #1;
        rx_vld = 1'b0; rd_start = 1'b1; rd_pending++;
        @(posedge clk); #1;
        rd_start = 1'b0;
        wait_quiet();
        chk(first_kind == 2, "R6 read served first", first_kind, 2);

        // R6/R8: hold the engine, ignore read request, overfill the queue
        hold = 1;
        s0 = wq.size();
        for (int i = 0; i < WR_LEN - 1; i++) push_byte(8'(8'h90 + i));
        repeat (4) @(posedge clk);
        pulse_rd(0);
        for (int i = 0; i < 260; i++) begin
            @(posedge clk); #1;
            rx_vld = 1'b1; rx_byte = 8'((i * 37 + 11) & 255);
        end
        @(posedge clk); #1 rx_vld = 1'b0;
        repeat (2) @(posedge clk);
        chk(wq.size() == DEPTH, "R8 queue full", wq.size(), DEPTH);
        chk(dropped == s0 + WR_LEN - 1 + 260 - DEPTH, "R8 dropped bytes",
            dropped, s0 + WR_LEN - 1 + 260 - DEPTH);
        hold = 0;
        wait_quiet();
        chk(rd_pending == 0, "R6 ignored read left nothing", rd_pending, 0);

        // R7: read after the write address has wrapped
        pulse_rd(1);
        wait_quiet();
        chk(txq.size() == 0 && exp_cmd.size() == 0, "R7 final read complete",
            txq.size() + exp_cmd.size(), 0);
        finish_tb();
    end
endmodule